// File: doc/BRIEF.md
# ATA Register Mapping Bridge

This block sits between a 64-bit system bus, which carries byte enables, and an ATA host controller core that only accepts 16-bit register writes. It decodes each bus access by word address and by its byte-enable pattern. Task-file accesses go to a shadow register port. DMA command and status accesses, the descriptor table pointer and a window of core registers go to the core register port, with one write strobe per cycle. The bus acknowledge is held off until every core-side write of an access has been issued.

The bridge keeps local copies of the state it must reproduce on its own. These are two transfer word counts, the device-select bit from the last device/head write, a copy of the system control register, the DMA command bits and the descriptor table pointer. One bus write can fan out into an ordered series of core writes. A device/head write becomes a task-file write, then a system control clear, then a word count update. A combined DMA status/command write becomes a status clear, then a direction update, then a start update. Access shapes the bridge does not support complete harmlessly and set a sticky error flag.

Top module: `ata_reg_bridge`

## Requirements
- R1: At word address 0, byte enables with bits 1:0 both set access the 16-bit data register (task-file index 0) in full: a write forwards wdata[15:0], and a read returns the register on rdata[15:0].
- R2: At word address 0 with byte enable 0 set and byte enable 1 clear, the data register is accessed with its upper byte forced to zero: a write forwards {8'h00, wdata[7:0]}, and a read returns zero in rdata[15:8].
- R3: At word address 0, when the lowest set byte enable is lane k (1..7), exactly one task-file write or read of index k takes place. The byte travels on lane k, with zero in the upper byte of the forwarded data. Index 1 is error/feature, 6 is device/head and 7 is command/status.
- R4: At word address 1, byte enables confined to lanes 3:0 access DMA command/status. A write with lane 2 set issues a status-clear core write (index 12) of wdata[23:16]. A write with lane 0 set issues a direction write (index 13) of wdata[3], then a start write (index 14) of wdata[0]. These writes go out on consecutive cycles in the order status, direction, start. A read returns {4'b0, direction, 2'b0, start} on rdata[7:0] and the low byte of core index 15 on rdata[23:16].
- R5: At word address 1, byte enables 8'hF0 access the 32-bit descriptor table pointer. A write issues core index 9 with wdata[47:32] and then core index 10 with wdata[63:48]. A read returns the stored pointer on rdata[63:32].
- R6: A write to device/head (word 0, lane 6) issues the task-file write. On the next cycle it writes core index 0 with the system control copy masked to its mode fields (bits 7:0 by default), and the copy keeps only those bits.
- R7: The device bit is bit 4 of the last byte written to device/head, and it is zero after reset. A device/head write ends with a core index 11 write of the word count the new bit selects (count 1 for 0, count 2 for 1). A count write is forwarded to core index 11 only if that count is the selected one.
- R8: Transfer word counts 1 and 2 sit at word addresses 2 and 3 with byte enables 8'h03. Reads return the local copies.
- R9: Word addresses 4 to 11 with byte enables 8'h03 map one-to-one to core register indices 0 to 7. Writes forward wdata[15:0], and reads return the core data on rdata[15:0].
- R10: Any other access shape acknowledges with zero read data and no write strobe, and it sets the sticky error flag. The unsupported shapes are an empty byte-enable set, a byte access to a halfword register, a mixed or 64-bit access at word 1, and an unmapped address.
- R11: ack_o is a single-cycle pulse that follows the last core-side write of the access. At most one of the four core-side strobes is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus request, held until ack_o |
| we_i | input | 1 | Bus write when 1, read when 0 |
| addr_i | input | AW | 64-bit word address |
| be_i | input | 8 | Byte enables |
| wdata_i | input | 64 | Bus write data |
| ack_o | output | 1 | Access complete pulse |
| rdata_o | output | 64 | Read data, valid with ack_o |
| err_o | output | 1 | Sticky unsupported-access flag |
| tf_we_o | output | 1 | Task-file write strobe |
| tf_re_o | output | 1 | Task-file read strobe |
| tf_idx_o | output | 3 | Task-file register index |
| tf_wdata_o | output | 16 | Task-file write data |
| tf_rdata_i | input | 16 | Task-file read data, same cycle as tf_re_o |
| core_we_o | output | 1 | Core register write strobe |
| core_re_o | output | 1 | Core register read strobe |
| core_idx_o | output | 4 | Core register index |
| core_wdata_o | output | 16 | Core write data |
| core_rdata_i | input | 16 | Core read data, same cycle as core_re_o |

## Verification
Data register accesses are tried with the full, low-byte-only and lane-1-lowest enable patterns. These separate a 16-bit access, a zero-extended access and an error/feature access that lands at the same address. Random task-file writes with random upper enable lanes confirm that only the lowest lane counts. Device/head writes with either value of the device bit, followed by writes of both counts, tell a correctly steered word count from a swapped or stale one. DMA writes with status and command enabled together, and with the command alone, expose any reordering of the core-side sequence. Malformed shapes show that no side effect leaks out.

// File: rtl/ata_bridge_pkg.sv
package ata_bridge_pkg;
  localparam int unsigned CIW  = 4;
  localparam int unsigned NOPS = 3;  // longest core-side sequence per bus write

  localparam logic [CIW-1:0] CI_SYSCTL  = 4'd0;
  localparam logic [CIW-1:0] CI_PTR_LO  = 4'd9;
  localparam logic [CIW-1:0] CI_PTR_HI  = 4'd10;
  localparam logic [CIW-1:0] CI_WCNT    = 4'd11;
  localparam logic [CIW-1:0] CI_STATCLR = 4'd12;
  localparam logic [CIW-1:0] CI_DIR     = 4'd13;
  localparam logic [CIW-1:0] CI_START   = 4'd14;
  localparam logic [CIW-1:0] CI_STAT    = 4'd15;
  localparam logic [2:0]     TF_DEVHEAD = 3'd6;

  typedef struct packed {
    logic           vld;
    logic           to_core;
    logic [CIW-1:0] idx;
    logic [15:0]    data;
  } op_t;

  typedef enum logic [2:0] {RK_NONE, RK_TF, RK_CORE, RK_DMA, RK_PTR, RK_XC1, RK_XC2} rkind_e;

  typedef struct packed {
    logic           err;
    rkind_e         rk;
    logic [CIW-1:0] ridx;
    logic [2:0]     lane;
    logic           full;
    logic           dh_wr;
    logic [7:0]     dh_byte;
    logic           sys_wr;
    logic           xc1_wr;
    logic           xc2_wr;
    logic           cmd_wr;
    logic           ptr_wr;
  } dec_t;

  function automatic op_t mk_op(logic to_core, logic [CIW-1:0] idx, logic [15:0] data);
    op_t o;
    o.vld = 1'b1;
    o.to_core = to_core;
    o.idx = idx;
    o.data = data;
    return o;
  endfunction
endpackage

// File: rtl/ata_addr_decode.sv
module ata_addr_decode
  import ata_bridge_pkg::*;
#(
  parameter int unsigned AW        = 8,
  parameter int unsigned WIN       = 8,
  parameter logic [15:0] MODE_MASK = 16'h00FF
) (
  input  logic [AW-1:0]        addr_i,
  input  logic [7:0]           be_i,
  input  logic                 we_i,
  input  logic [63:0]          wdata_i,
  input  logic                 dev_i,
  input  logic [15:0]          sysctl_i,
  input  logic [15:0]          xc1_i,
  input  logic [15:0]          xc2_i,
  output op_t  [NOPS-1:0]      ops_o,
  output dec_t                 dec_o
);
  localparam logic [AW-1:0] WIN_LO = AW'(4);
  localparam logic [AW-1:0] WIN_HI = AW'(4 + WIN);

  logic [2:0] lane;
  logic [7:0] lbyte;
  logic       in_win;

  always_comb begin
    lane = 3'd0;
    for (int i = 7; i >= 0; i--) if (be_i[i]) lane = 3'(i);
  end

  assign lbyte  = wdata_i[{lane, 3'b000} +: 8];
  assign in_win = (addr_i >= WIN_LO) && (addr_i < WIN_HI);

  always_comb begin
    ops_o = '0;
    dec_o = '0;
    dec_o.lane = lane;
    dec_o.dh_byte = lbyte;
    if (addr_i == AW'(0)) begin
      if (be_i == 8'h00) dec_o.err = 1'b1;
      else if (lane == 3'd0) begin
        dec_o.rk   = RK_TF;
        dec_o.full = be_i[1];
        if (we_i) ops_o[0] = mk_op(1'b0, '0, be_i[1] ? wdata_i[15:0] : {8'h00, wdata_i[7:0]});
      end else begin
        dec_o.rk = RK_TF;
        if (we_i) begin
          ops_o[0] = mk_op(1'b0, CIW'(lane), {8'h00, lbyte});
          if (lane == TF_DEVHEAD) begin
            dec_o.dh_wr = 1'b1;
            ops_o[1] = mk_op(1'b1, CI_SYSCTL, sysctl_i & MODE_MASK);
            ops_o[2] = mk_op(1'b1, CI_WCNT, lbyte[4] ? xc2_i : xc1_i);
          end
        end
      end
    end else if (addr_i == AW'(1)) begin
      if (be_i == 8'hF0) begin
        dec_o.rk = RK_PTR;
        if (we_i) begin
          dec_o.ptr_wr = 1'b1;
          ops_o[0] = mk_op(1'b1, CI_PTR_LO, wdata_i[47:32]);
          ops_o[1] = mk_op(1'b1, CI_PTR_HI, wdata_i[63:48]);
        end
      end else if (be_i[7:4] == 4'h0 && be_i[3:0] != 4'h0) begin
        dec_o.rk   = RK_DMA;
        dec_o.ridx = CI_STAT;
        if (we_i) begin
          dec_o.cmd_wr = be_i[0];
          // status clear, then direction, then start
          if (be_i[2]) begin
            ops_o[0] = mk_op(1'b1, CI_STATCLR, {8'h00, wdata_i[23:16]});
            if (be_i[0]) begin
              ops_o[1] = mk_op(1'b1, CI_DIR, {15'h0, wdata_i[3]});
              ops_o[2] = mk_op(1'b1, CI_START, {15'h0, wdata_i[0]});
            end
          end else if (be_i[0]) begin
            ops_o[0] = mk_op(1'b1, CI_DIR, {15'h0, wdata_i[3]});
            ops_o[1] = mk_op(1'b1, CI_START, {15'h0, wdata_i[0]});
          end
        end
      end else dec_o.err = 1'b1;
    end else if (addr_i == AW'(2) || addr_i == AW'(3)) begin
      if (be_i == 8'h03) begin
        dec_o.rk = (addr_i == AW'(2)) ? RK_XC1 : RK_XC2;
        if (we_i) begin
          dec_o.xc1_wr = (addr_i == AW'(2));
          dec_o.xc2_wr = (addr_i == AW'(3));
          if ((addr_i == AW'(3)) == dev_i) ops_o[0] = mk_op(1'b1, CI_WCNT, wdata_i[15:0]);
        end
      end else dec_o.err = 1'b1;
    end else if (in_win) begin
      if (be_i == 8'h03) begin
        dec_o.rk   = RK_CORE;
        dec_o.ridx = CIW'(addr_i - WIN_LO);
        if (we_i) begin
          dec_o.sys_wr = (addr_i == WIN_LO);
          ops_o[0] = mk_op(1'b1, CIW'(addr_i - WIN_LO), wdata_i[15:0]);
        end
      end else dec_o.err = 1'b1;
    end else dec_o.err = 1'b1;
  end
endmodule

// File: rtl/ata_op_seq.sv
module ata_op_seq
  import ata_bridge_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  op_t [NOPS-1:0] ops_i,
  input  logic           shift_i,
  output op_t            head_o,
  output logic           more_o
);
  op_t [NOPS-1:0] ops_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ops_q <= '0;
    else if (load_i)  ops_q <= ops_i;
    else if (shift_i) ops_q <= {op_t'('0), ops_q[NOPS-1:1]};
  end

  assign head_o = ops_q[0];
  assign more_o = ops_q[1].vld;
endmodule

// File: rtl/ata_rd_mux.sv
module ata_rd_mux
  import ata_bridge_pkg::*;
(
  input  rkind_e      rk_i,
  input  logic [2:0]  lane_i,
  input  logic        full_i,
  input  logic [15:0] tf_rdata_i,
  input  logic [15:0] core_rdata_i,
  input  logic        dir_i,
  input  logic        start_i,
  input  logic [31:0] ptr_i,
  input  logic [15:0] xc1_i,
  input  logic [15:0] xc2_i,
  output logic [63:0] rdata_o
);
  always_comb begin
    case (rk_i)
      RK_TF:
        if (lane_i == 3'd0) rdata_o = {48'h0, full_i ? tf_rdata_i[15:8] : 8'h00, tf_rdata_i[7:0]};
        else                rdata_o = {56'h0, tf_rdata_i[7:0]} << {lane_i, 3'b000};
      RK_CORE: rdata_o = {48'h0, core_rdata_i};
      RK_DMA:  rdata_o = {40'h0, core_rdata_i[7:0], 8'h00, 4'h0, dir_i, 2'b00, start_i};
      RK_PTR:  rdata_o = {ptr_i, 32'h0};
      RK_XC1:  rdata_o = {48'h0, xc1_i};
      RK_XC2:  rdata_o = {48'h0, xc2_i};
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ata_reg_bridge.sv
module ata_reg_bridge
  import ata_bridge_pkg::*;
#(
  parameter int unsigned AW        = 8,
  parameter int unsigned WIN       = 8,
  parameter logic [15:0] MODE_MASK = 16'h00FF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    be_i,
  input  logic [63:0]   wdata_i,
  output logic          ack_o,
  output logic [63:0]   rdata_o,
  output logic          err_o,
  output logic          tf_we_o,
  output logic          tf_re_o,
  output logic [2:0]    tf_idx_o,
  output logic [15:0]   tf_wdata_o,
  input  logic [15:0]   tf_rdata_i,
  output logic          core_we_o,
  output logic          core_re_o,
  output logic [3:0]    core_idx_o,
  output logic [15:0]   core_wdata_o,
  input  logic [15:0]   core_rdata_i
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_OPS, S_ACK} st_e;

  st_e            st_q;
  op_t [NOPS-1:0] dec_ops;
  dec_t           dec;
  op_t            head;
  logic           more, accept, load;
  rkind_e         rk_q;
  logic [CIW-1:0] ridx_q;
  logic [2:0]     lane_q;
  logic           full_q, err_q, dev_q, dir_q, start_q;
  logic [15:0]    sysctl_q, xc1_q, xc2_q;
  logic [31:0]    ptr_q;
  logic [63:0]    rmux, rdata_q;

  ata_addr_decode #(.AW(AW), .WIN(WIN), .MODE_MASK(MODE_MASK)) i_dec (
    .addr_i(addr_i), .be_i(be_i), .we_i(we_i), .wdata_i(wdata_i),
    .dev_i(dev_q), .sysctl_i(sysctl_q), .xc1_i(xc1_q), .xc2_i(xc2_q),
    .ops_o(dec_ops), .dec_o(dec)
  );

  assign accept = (st_q == S_IDLE) && req_i;
  assign load   = accept && we_i && !dec.err;

  ata_op_seq i_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .ops_i(dec_ops),
    .shift_i(st_q == S_OPS), .head_o(head), .more_o(more)
  );

  ata_rd_mux i_rmux (
    .rk_i(rk_q), .lane_i(lane_q), .full_i(full_q), .tf_rdata_i(tf_rdata_i),
    .core_rdata_i(core_rdata_i), .dir_i(dir_q), .start_i(start_q), .ptr_i(ptr_q),
    .xc1_i(xc1_q), .xc2_i(xc2_q), .rdata_o(rmux)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      rk_q    <= RK_NONE;
      ridx_q  <= '0;
      lane_q  <= '0;
      full_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (req_i) begin
          rdata_q <= '0;
          rk_q    <= dec.rk;
          ridx_q  <= dec.ridx;
          lane_q  <= dec.lane;
          full_q  <= dec.full;
          if (dec.err)    st_q <= S_ACK;
          else if (!we_i) st_q <= S_RD;
          else            st_q <= dec_ops[0].vld ? S_OPS : S_ACK;
        end
        S_RD: begin
          rdata_q <= rmux;
          st_q    <= S_ACK;
        end
        S_OPS:   if (!more) st_q <= S_ACK;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // local copies, updated when the write is accepted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q    <= 1'b0;
      dev_q    <= 1'b0;
      sysctl_q <= '0;
      xc1_q    <= '0;
      xc2_q    <= '0;
      dir_q    <= 1'b0;
      start_q  <= 1'b0;
      ptr_q    <= '0;
    end else begin
      if (accept && dec.err) err_q <= 1'b1;
      if (load) begin
        if (dec.dh_wr) begin
          dev_q    <= dec.dh_byte[4];
          sysctl_q <= sysctl_q & MODE_MASK;
        end
        if (dec.sys_wr) sysctl_q <= wdata_i[15:0];
        if (dec.xc1_wr) xc1_q <= wdata_i[15:0];
        if (dec.xc2_wr) xc2_q <= wdata_i[15:0];
        if (dec.cmd_wr) begin
          dir_q   <= wdata_i[3];
          start_q <= wdata_i[0];
        end
        if (dec.ptr_wr) ptr_q <= wdata_i[63:32];
      end
    end
  end

  assign ack_o        = (st_q == S_ACK);
  assign rdata_o      = rdata_q;
  assign err_o        = err_q;
  assign tf_we_o      = (st_q == S_OPS) && head.vld && !head.to_core;
  assign core_we_o    = (st_q == S_OPS) && head.vld && head.to_core;
  assign tf_re_o      = (st_q == S_RD) && (rk_q == RK_TF);
  assign core_re_o    = (st_q == S_RD) && (rk_q == RK_CORE || rk_q == RK_DMA);
  assign tf_idx_o     = (st_q == S_OPS) ? head.idx[2:0] : lane_q;
  assign core_idx_o   = (st_q == S_OPS) ? head.idx : ridx_q;
  assign tf_wdata_o   = head.data;
  assign core_wdata_o = head.data;
endmodule

// File: rtl/ata_reg_bridge_chk.sv
module ata_reg_bridge_chk
  import ata_bridge_pkg::*;
#(
  parameter logic [15:0] MODE_MASK = 16'h00FF
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ack_o,
  input logic        err_o,
  input logic        tf_we_o,
  input logic        tf_re_o,
  input logic [2:0]  tf_idx_o,
  input logic        core_we_o,
  input logic        core_re_o,
  input logic [3:0]  core_idx_o,
  input logic [15:0] core_wdata_o
);
  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tf_we_o, tf_re_o, core_we_o, core_re_o})); // R11
  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o); // R11
  AST_NO_WRITE_AT_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !(tf_we_o || core_we_o)); // R11
  AST_DIR_BEFORE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_we_o && core_idx_o == CI_START) |-> $past(core_we_o && core_idx_o == CI_DIR)); // R4
  AST_CLEAR_BEFORE_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_we_o && core_idx_o == CI_DIR && $past(core_we_o)) |-> $past(core_idx_o == CI_STATCLR)); // R4
  AST_DEVHEAD_CLEARS_CTL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tf_we_o && tf_idx_o == TF_DEVHEAD) |=>
      (core_we_o && core_idx_o == CI_SYSCTL && (core_wdata_o & ~MODE_MASK) == 16'h0)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R10
endmodule

bind ata_reg_bridge ata_reg_bridge_chk #(.MODE_MASK(MODE_MASK)) i_chk (.*);

// File: tb/test_ata_reg_bridge.sv
`timescale 1ns/1ps
module test_ata_reg_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [7:0]  be = '0;
  logic [63:0] wdata = '0;
  logic        ack, err, tf_we, tf_re, core_we, core_re;
  logic [63:0] rdata;
  logic [2:0]  tf_idx;
  logic [3:0]  core_idx;
  logic [15:0] tf_wdata, tf_rdata, core_wdata, core_rdata;

  int n_chk = 0, n_fail = 0, overlap = 0, cyc = 0;
  logic [20:0] log_e [8];
  int          log_n = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  function automatic logic [15:0] tf_val(logic [2:0] i);
    return {5'b10110, i, 5'b01001, i};
  endfunction
  function automatic logic [15:0] core_val(logic [3:0] i);
    return {i, 4'h0, i, 4'h5};
  endfunction
  function automatic logic [20:0] ent(bit c, int idx, logic [15:0] d);
    return {c, 4'(idx), d};
  endfunction

  assign tf_rdata   = tf_val(tf_idx);
  assign core_rdata = core_val(core_idx);

  ata_reg_bridge i_ata_reg_bridge (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .be_i(be),
    .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata), .err_o(err),
    .tf_we_o(tf_we), .tf_re_o(tf_re), .tf_idx_o(tf_idx), .tf_wdata_o(tf_wdata),
    .tf_rdata_i(tf_rdata), .core_we_o(core_we), .core_re_o(core_re),
    .core_idx_o(core_idx), .core_wdata_o(core_wdata), .core_rdata_i(core_rdata)
  );

  always @(negedge clk) begin
    cyc++;
    if ((32'(tf_we) + 32'(tf_re) + 32'(core_we) + 32'(core_re)) > 1) overlap++;
    if (log_n < 8) begin
      if (tf_we)   begin log_e[log_n] = ent(1'b0, 32'(tf_idx), tf_wdata); log_n++; end
      if (core_we) begin log_e[log_n] = ent(1'b1, 32'(core_idx), core_wdata); log_n++; end
    end
  end

  task automatic chk(bit ok, string r, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic xfer(bit w, logic [7:0] a, logic [7:0] b, logic [63:0] d, output logic [63:0] rd);
    int n = 0;
    @(negedge clk);
    log_n = 0;
    req = 1'b1; we = w; addr = a; be = b; wdata = d;
    do begin
      @(negedge clk);
      n++;
    end while (!ack && n < 20);
    rd = rdata;
    req = 1'b0;
    if (!ack) chk(1'b0, "R11 ack timeout", 64'(n), 64'd0);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] b, logic [63:0] d);
    logic [63:0] rd;
    xfer(1'b1, a, b, d, rd);
  endtask

  task automatic rd_chk(logic [7:0] a, logic [7:0] b, logic [63:0] exp, string r);
    logic [63:0] rd;
    xfer(1'b0, a, b, 64'h0, rd);
    chk(rd === exp, r, rd, exp);
  endtask

  task automatic log_chk(int n, logic [20:0] e0, logic [20:0] e1, logic [20:0] e2, string r);
    logic [20:0] ex [3];
    ex[0] = e0; ex[1] = e1; ex[2] = e2;
    chk(log_n == n, r, 64'(log_n), 64'(n));
    for (int i = 0; i < n && i < log_n; i++)
      chk(log_e[i] === ex[i], r, 64'(log_e[i]), 64'(ex[i]));
  endtask

  task automatic finish_test();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    wait (cyc > 100000);
    chk(1'b0, "R11 watchdog", 64'(cyc), 64'd0);
    finish_test();
  end

  initial begin
    logic [63:0] d;
    int unsigned s;
    s = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    chk({ack, err, tf_we, tf_re, core_we, core_re} == 6'b0, "R11 reset state",
        64'({ack, err, tf_we, tf_re, core_we, core_re}), 64'd0);
    rst_n = 1'b1;

    // R1 full data register
    wr(8'd0, 8'h03, 64'h1234);
    log_chk(1, ent(0, 0, 16'h1234), '0, '0, "R1 data write");
    rd_chk(8'd0, 8'h03, {48'h0, tf_val(3'd0)}, "R1 data read");
    // R2 low byte only
    wr(8'd0, 8'h01, 64'hABCD);
    log_chk(1, ent(0, 0, 16'h00CD), '0, '0, "R2 low byte write");
    rd_chk(8'd0, 8'h01, {56'h0, tf_val(3'd0)[7:0]}, "R2 low byte read");
    // R3 feature / error on lane 1
    wr(8'd0, 8'h02, 64'h5E00);
    log_chk(1, ent(0, 1, 16'h005E), '0, '0, "R3 feature write");
    rd_chk(8'd0, 8'h06, {48'h0, tf_val(3'd1)[7:0], 8'h00}, "R3 error read");
    for (int i = 0; i < 30; i++) begin
      int l;
      logic [7:0] b;
      l = 1 + int'($urandom % 7);
      if (l == 6) l = 7;
      b = (8'($urandom) & ~8'((1 << l) - 1)) | 8'(1 << l);
      d = {$urandom, $urandom};
      wr(8'd0, b, d);
      log_chk(1, ent(0, l, {8'h00, d[8*l +: 8]}), '0, '0, "R3 random lane write");
    end

    // R7 R8 counts with device bit 0
    wr(8'd2, 8'h03, 64'h0100);
    log_chk(1, ent(1, 11, 16'h0100), '0, '0, "R7 count1 forwarded dev0");
    wr(8'd3, 8'h03, 64'h0200);
    log_chk(0, '0, '0, '0, "R7 count2 held dev0");
    rd_chk(8'd3, 8'h03, 64'h0200, "R8 count2 readback");
    rd_chk(8'd2, 8'h03, 64'h0100, "R8 count1 readback");

    // R9 core window
    wr(8'd4, 8'h03, 64'hBEEF);
    log_chk(1, ent(1, 0, 16'hBEEF), '0, '0, "R9 sysctl write");
    rd_chk(8'd6, 8'h03, {48'h0, core_val(4'd2)}, "R9 window read");

    // R6 R7 device/head with dev=1
    wr(8'd0, 8'h40, 64'h0010_0000_0000_0000);
    log_chk(3, ent(0, 6, 16'h0010), ent(1, 0, 16'h00EF), ent(1, 11, 16'h0200), "R6 devhead sequence");
    wr(8'd2, 8'h03, 64'h0111);
    log_chk(0, '0, '0, '0, "R7 count1 held dev1");
    wr(8'd3, 8'h03, 64'h0222);
    log_chk(1, ent(1, 11, 16'h0222), '0, '0, "R7 count2 forwarded dev1");
    wr(8'd0, 8'h40, 64'h00E0_0000_0000_0000);
    log_chk(3, ent(0, 6, 16'h00E0), ent(1, 0, 16'h00EF), ent(1, 11, 16'h0111), "R7 devhead back to dev0");

    // R4 DMA ordering
    wr(8'd1, 8'h05, 64'h0006_0009);
    log_chk(3, ent(1, 12, 16'h0006), ent(1, 13, 16'h0001), ent(1, 14, 16'h0001), "R4 status dir start");
    rd_chk(8'd1, 8'h01, {40'h0, core_val(4'd15)[7:0], 8'h00, 8'h09}, "R4 dma read");
    wr(8'd1, 8'h01, 64'h08);
    log_chk(2, ent(1, 13, 16'h0001), ent(1, 14, 16'h0000), '0, "R4 dir start only");

    // R5 pointer
    wr(8'd1, 8'hF0, 64'hDEAD_BEEF_0000_0000);
    log_chk(2, ent(1, 9, 16'hBEEF), ent(1, 10, 16'hDEAD), '0, "R5 pointer write");
    rd_chk(8'd1, 8'hF0, 64'hDEAD_BEEF_0000_0000, "R5 pointer read");

    // R10 unsupported shapes
    chk(err == 1'b0, "R10 no error yet", 64'(err), 64'd0);
    wr(8'd1, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF);
    log_chk(0, '0, '0, '0, "R10 64-bit dma write");
    chk(err == 1'b1, "R10 sticky error set", 64'(err), 64'd1);
    rd_chk(8'd1, 8'hFF, 64'h0, "R10 64-bit read zero");
    wr(8'd4, 8'h01, 64'h77);
    log_chk(0, '0, '0, '0, "R10 byte access to core");
    wr(8'd0, 8'h00, 64'h55);
    log_chk(0, '0, '0, '0, "R10 empty enables");
    rd_chk(8'd20, 8'h03, 64'h0, "R10 unmapped read");
    rd_chk(8'd1, 8'hF0, 64'hDEAD_BEEF_0000_0000, "R10 pointer untouched");
    chk(err == 1'b1, "R10 error stays", 64'(err), 64'd1);

    // R9 random window writes
    for (int i = 0; i < 20; i++) begin
      int a;
      a = int'($urandom % 8);
      d = {$urandom, $urandom};
      wr(8'(4 + a), 8'h03, d);
      log_chk(1, ent(1, a, d[15:0]), '0, '0, "R9 random window write");
    end

    chk(overlap == 0, "R11 strobe overlap", 64'(overlap), 64'd0);
    finish_test();
  end
endmodule